// File: doc/BRIEF.md
# Burst Ramp Timing Sequencer

This block generates the timing strobes that walk an external analog integrator through one transmit burst. It divides the master clock into a slow internal cycle, resamples a burst trigger on that cycle, and runs a four-phase machine: home, kick, level and fall. Each phase drives one switch-control output. The home output also follows a direct-control input, so the integrator's home switch can be held closed while the loop is open.

A rising trigger releases the home hold and starts a fixed-length kick. The power-level phase follows and lasts as long as the trigger stays high. A falling trigger starts a fixed-length quick ramp-down, and the machine then returns home. An active-low sleep input forces the home phase at once. If the master clock stops, the machine freezes.

Top module: `burst_ramp_seq`

## Requirements
- R1: All phase changes, except those forced by sleep, happen only on the internal tick, which occurs once every DIV (default 6) master clocks. Every timed phase length is therefore a whole number of ticks.
- R2: A trigger edge acts in the third internal tick after it is applied, because it passes through two tick-clocked resampling stages. Measured on the outputs, this is 2*DIV+1 to 3*DIV master clocks after the edge.
- R3: In the home phase, a high resampled trigger moves the machine to the kick phase: kick_sw_o rises and the internal home hold drops.
- R4: The kick phase lasts exactly KICK_CYC (default 18) ticks if the trigger stays high. The machine then enters the level phase: level_sw_o rises and kick_sw_o falls.
- R5: The level phase holds for as long as the resampled trigger stays high.
- R6: A low resampled trigger in the level phase starts the fall phase: level_sw_o drops and fall_sw_o rises.
- R7: The fall phase lasts exactly FALL_CYC (default 38) ticks. The machine then returns home and the home hold is asserted again.
- R8: While sleep_ni is low, the machine is forced to home on the next master clock, clears its counters and resampling stages, and stays home whatever the trigger does. After release, a trigger that is already high starts a kick with the R2 latency.
- R9: home_sw_o equals the internal home hold ORed with direct_i.
- R10: A low resampled trigger during the kick phase goes straight to the fall phase. The level phase is skipped.
- R11: If the resampled trigger is seen low on the same tick that ends the kick count, the fall phase wins and the level phase is never entered.
- R12: Trigger activity during the fall phase is ignored. If the trigger is high when home is reached, a kick starts on the next tick, exactly DIV master clocks later.
- R13: After reset the phase is home. phase_o encodes the phase as 0 = home, 1 = kick, 2 = level and 3 = fall. Exactly the one strobe that matches the phase is high, and home_sw_o is high in home.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_ni | input | 1 | Active-low power-down; low forces home |
| burst_i | input | 1 | Burst trigger |
| direct_i | input | 1 | Direct-control bit, ORed into the home switch |
| home_sw_o | output | 1 | Home-position hold switch control |
| kick_sw_o | output | 1 | Kick-voltage switch control |
| level_sw_o | output | 1 | Power-level connect switch control |
| fall_sw_o | output | 1 | Quick ramp-down switch control |
| phase_o | output | 2 | Current phase code (see R13) |

## Verification
Two events can fall on the same tick: the end of the kick count and the arrival of a low resampled trigger. Both want to leave the kick phase, for different destinations. The bench provokes this by dropping the trigger in the one six-clock window, 93 master clocks after the kick strobe is seen, that makes the resampled low land on the eighteenth kick tick. The scoreboard then expects fall_sw_o exactly 108 clocks after kick entry, with no level phase in between. Two nearby cases are judged the same way: a drop well inside the kick phase, and a trigger held high through the fall phase so that home and a new kick meet on consecutive ticks.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [1:0] {
    PH_HOME  = 2'd0,
    PH_KICK  = 2'd1,
    PH_LEVEL = 2'd2,
    PH_FALL  = 2'd3
  } phase_e;
endpackage

// File: rtl/brs_rst_sync.sv
module brs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/brs_tick_div.sv
module brs_tick_div #(
  parameter int DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    tick_d = (cnt_q == LAST);
    cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R1: ticks never come on adjacent master clocks
  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
endmodule

// File: rtl/brs_trig_sync.sv
module brs_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic trig_i,
  output logic trig_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (!run_i)      sh_d = '0;
    else if (tick_i) sh_d = {sh_q[STAGES-2:0], trig_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign trig_o = sh_q[STAGES-1];

  // R8: the resampling stages stay cleared while asleep
  p_sync_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (trig_o == 1'b0));
endmodule

// File: rtl/brs_phase_fsm.sv
module brs_phase_fsm
  import brs_pkg::*;
#(
  parameter int KICK_CYC = 18,
  parameter int FALL_CYC = 38
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   run_i,
  input  logic   trig_s_i,
  output phase_e phase_o
);
  localparam int CNT_MAX = (KICK_CYC > FALL_CYC) ? KICK_CYC : FALL_CYC;
  localparam int CW      = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;
  localparam logic [CW-1:0] KICK_LAST = CW'(KICK_CYC - 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!run_i) begin
      ph_d  = PH_HOME;
      cnt_d = '0;
    end else if (tick_i) begin
      unique case (ph_q)
        PH_HOME: begin
          if (trig_s_i) begin
            ph_d  = PH_KICK;
            cnt_d = '0;
          end
        end
        PH_KICK: begin
          // a dropped trigger outranks the end of the kick count
          if (!trig_s_i) begin
            ph_d  = PH_FALL;
            cnt_d = '0;
          end else if (cnt_q == KICK_LAST) begin
            ph_d  = PH_LEVEL;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_LEVEL: begin
          if (!trig_s_i) begin
            ph_d  = PH_FALL;
            cnt_d = '0;
          end
        end
        PH_FALL: begin
          if (cnt_q == FALL_LAST) begin
            ph_d  = PH_HOME;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          ph_d  = PH_HOME;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_HOME;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = ph_q;

  // R1: phase moves only on a tick, or when forced by sleep
  p_tick_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != $past(ph_q)) |-> ($past(tick_i) || !$past(run_i)));
  // R3: the kick is entered only from home with a high trigger
  p_kick_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_KICK && $past(ph_q) != PH_KICK) |->
      ($past(ph_q) == PH_HOME && $past(trig_s_i)));
  // R4: the level phase follows a full kick count
  p_level_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_LEVEL && $past(ph_q) != PH_LEVEL) |->
      ($past(ph_q) == PH_KICK && $past(cnt_q) == KICK_LAST));
  // R7: home after fall only at the end of the fall count or by sleep
  p_home_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_HOME && $past(ph_q) == PH_FALL) |->
      ($past(cnt_q) == FALL_LAST || !$past(run_i)));
  // R8: sleep forces home on the next clock
  p_sleep_home_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (ph_q == PH_HOME));
endmodule

// File: rtl/burst_ramp_seq.sv
module burst_ramp_seq
  import brs_pkg::*;
#(
  parameter int DIV         = 6,
  parameter int SYNC_STAGES = 2,
  parameter int KICK_CYC    = 18,
  parameter int FALL_CYC    = 38
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_ni,
  input  logic       burst_i,
  input  logic       direct_i,
  output logic       home_sw_o,
  output logic       kick_sw_o,
  output logic       level_sw_o,
  output logic       fall_sw_o,
  output logic [1:0] phase_o
);
  logic   rst_n;
  logic   tick;
  logic   trig_s;
  phase_e phase;

  brs_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  brs_tick_div #(.DIV(DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_o (tick)
  );

  brs_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_i (tick),
    .run_i  (sleep_ni),
    .trig_i (burst_i),
    .trig_o (trig_s)
  );

  brs_phase_fsm #(.KICK_CYC(KICK_CYC), .FALL_CYC(FALL_CYC)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .run_i    (sleep_ni),
    .trig_s_i (trig_s),
    .phase_o  (phase)
  );

  always_comb begin
    home_sw_o  = (phase == PH_HOME) | direct_i;
    kick_sw_o  = (phase == PH_KICK);
    level_sw_o = (phase == PH_LEVEL);
    fall_sw_o  = (phase == PH_FALL);
    phase_o    = phase;
  end

  // R13: at most one ramp strobe high at a time
  p_strobe_excl_r13: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({kick_sw_o, level_sw_o, fall_sw_o}));
endmodule

// File: tb/burst_ramp_seq_test.sv
module burst_ramp_seq_test;
  localparam int DIV = 6;
  localparam int KC  = 18;
  localparam int FC  = 38;
  localparam logic [1:0] HOME = 2'd0, KICK = 2'd1, LEVEL = 2'd2, FALL = 2'd3;

  typedef struct {
    logic [1:0] ph;
    bit         from_trig;
    int         lo;
    int         hi;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, sleep_n, trig, direct;
  logic home_sw, kick_sw, level_sw, fall_sw;
  logic [1:0] phase;

  int checks = 0, failures = 0;
  int ncnt = 0, t_trig = 0, t_last = 0;
  logic [1:0] prev_ph = 2'd0;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) ncnt <= ncnt + 1;

  burst_ramp_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_ni(sleep_n), .burst_i(trig),
    .direct_i(direct), .home_sw_o(home_sw), .kick_sw_o(kick_sw),
    .level_sw_o(level_sw), .fall_sw_o(fall_sw), .phase_o(phase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] ph, input bit ft, input int lo, input int hi,
                      input string req);
    exp_t e;
    e.ph = ph; e.from_trig = ft; e.lo = lo; e.hi = hi; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_phase(input logic [1:0] ph);
    @(negedge clk);
    while (phase != ph) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: pops one expected item per phase change
  always @(negedge clk) begin
    if (rst_n && phase !== prev_ph) begin
      if (q.size() == 0) begin
        check(1'b0, "unexpected phase change", phase, prev_ph);
      end else begin
        exp_t e;
        int el;
        e = q.pop_front();
        el = ncnt - (e.from_trig ? t_trig : t_last);
        check(phase == e.ph, e.req, phase, e.ph);
        check(el >= e.lo && el <= e.hi, e.req, el, e.lo);
        // R13 strobe pattern follows the phase code
        check({kick_sw, level_sw, fall_sw} ==
              {phase == KICK, phase == LEVEL, phase == FALL}, "R13 strobes",
              {kick_sw, level_sw, fall_sw}, phase);
      end
      t_last  = ncnt;
      prev_ph = phase;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; sleep_n = 1'b1; trig = 1'b0; direct = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R13 reset state
    check(phase == HOME, "R13 phase", phase, HOME);
    check(home_sw && !kick_sw && !level_sw && !fall_sw, "R13 outputs",
          {home_sw, kick_sw, level_sw, fall_sw}, 4'b1000);

    // normal burst: R2 R3 R1 R4 R5 R6 R7
    push(KICK, 1, 2*DIV+1, 3*DIV, "R2,R3");
    push(LEVEL, 0, KC*DIV, KC*DIV, "R1,R4");
    trig = 1'b1; t_trig = ncnt;
    wait_phase(LEVEL);
    repeat (300) @(negedge clk);
    check(phase == LEVEL && level_sw, "R5 level held", phase, LEVEL);
    push(FALL, 1, 2*DIV+1, 3*DIV, "R6");
    push(HOME, 0, FC*DIV, FC*DIV, "R7");
    trig = 1'b0; t_trig = ncnt;
    wait_phase(HOME);
    repeat (30) @(negedge clk);

    // direct control R9
    direct = 1'b1;
    @(negedge clk);
    check(home_sw == 1'b1, "R9 home with direct", home_sw, 1);
    push(KICK, 1, 2*DIV+1, 3*DIV, "R3");
    push(LEVEL, 0, KC*DIV, KC*DIV, "R4");
    trig = 1'b1; t_trig = ncnt;
    wait_phase(LEVEL);
    repeat (5) @(negedge clk);
    check(home_sw && level_sw, "R9 direct in level", home_sw, 1);
    direct = 1'b0;
    @(negedge clk);
    check(home_sw == 1'b0, "R9 released in level", home_sw, 0);
    push(FALL, 1, 2*DIV+1, 3*DIV, "R6");
    push(HOME, 0, FC*DIV, FC*DIV, "R7");
    trig = 1'b0; t_trig = ncnt;
    wait_phase(HOME);
    repeat (30) @(negedge clk);

    // R10 early drop during kick
    push(KICK, 1, 2*DIV+1, 3*DIV, "R3");
    trig = 1'b1; t_trig = ncnt;
    wait_phase(KICK);
    repeat (30) @(negedge clk);
    push(FALL, 1, 2*DIV+1, 3*DIV, "R10");
    push(HOME, 0, FC*DIV, FC*DIV, "R7");
    trig = 1'b0; t_trig = ncnt;
    wait_phase(HOME);
    repeat (30) @(negedge clk);

    // R11 drop lands on the last kick tick
    push(KICK, 1, 2*DIV+1, 3*DIV, "R3");
    trig = 1'b1; t_trig = ncnt;
    wait_phase(KICK);
    repeat (15*DIV + DIV/2) @(negedge clk);
    push(FALL, 0, KC*DIV, KC*DIV, "R11");
    push(HOME, 0, FC*DIV, FC*DIV, "R7");
    trig = 1'b0; t_trig = ncnt;
    wait_phase(HOME);
    repeat (30) @(negedge clk);

    // R12 short pulse during fall is ignored
    push(KICK, 1, 2*DIV+1, 3*DIV, "R3");
    push(LEVEL, 0, KC*DIV, KC*DIV, "R4");
    trig = 1'b1; t_trig = ncnt;
    wait_phase(LEVEL);
    push(FALL, 1, 2*DIV+1, 3*DIV, "R6");
    trig = 1'b0; t_trig = ncnt;
    wait_phase(FALL);
    push(HOME, 0, FC*DIV, FC*DIV, "R12");
    repeat (50) @(negedge clk);
    trig = 1'b1;
    repeat (20) @(negedge clk);
    trig = 1'b0;
    wait_phase(HOME);
    repeat (60) @(negedge clk);
    check(phase == HOME, "R12 pulse ignored", phase, HOME);

    // R12 trigger held through fall: home then kick on next tick
    push(KICK, 1, 2*DIV+1, 3*DIV, "R3");
    push(LEVEL, 0, KC*DIV, KC*DIV, "R4");
    trig = 1'b1; t_trig = ncnt;
    wait_phase(LEVEL);
    push(FALL, 1, 2*DIV+1, 3*DIV, "R6");
    trig = 1'b0; t_trig = ncnt;
    wait_phase(FALL);
    repeat (50) @(negedge clk);
    push(HOME, 0, FC*DIV, FC*DIV, "R7");
    push(KICK, 0, DIV, DIV, "R12");
    push(LEVEL, 0, KC*DIV, KC*DIV, "R4");
    trig = 1'b1;
    wait_phase(LEVEL);
    push(FALL, 1, 2*DIV+1, 3*DIV, "R6");
    push(HOME, 0, FC*DIV, FC*DIV, "R7");
    trig = 1'b0; t_trig = ncnt;
    wait_phase(HOME);
    repeat (30) @(negedge clk);

    // R8 sleep forces home, then release restarts
    push(KICK, 1, 2*DIV+1, 3*DIV, "R3");
    push(LEVEL, 0, KC*DIV, KC*DIV, "R4");
    trig = 1'b1; t_trig = ncnt;
    wait_phase(LEVEL);
    push(HOME, 1, 1, 1, "R8");
    sleep_n = 1'b0; t_trig = ncnt;
    repeat (40) @(negedge clk);
    check(phase == HOME && home_sw, "R8 held home", phase, HOME);
    push(KICK, 1, 2*DIV+1, 3*DIV, "R8");
    push(LEVEL, 0, KC*DIV, KC*DIV, "R4");
    sleep_n = 1'b1; t_trig = ncnt;
    wait_phase(LEVEL);
    push(FALL, 1, 2*DIV+1, 3*DIV, "R6");
    push(HOME, 0, FC*DIV, FC*DIV, "R7");
    trig = 1'b0; t_trig = ncnt;
    wait_phase(HOME);
    repeat (20) @(negedge clk);

    check(q.size() == 0, "scoreboard drained", q.size(), 0);
    summary();
  end
endmodule